// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master from the system clock. A byte engine asks for a transfer with a start request. The block first holds the bus in the start condition for a timed interval, with SDA already low and SCL still released. It then runs alternating low and high SCL phases until the engine asks it to stop. The phase lengths come from two pairs of high/low counts, one pair for standard speed and one for fast speed, and a speed input picks the pair.

SCL is open drain. The block only ever pulls the line low or lets it go. It reads the line back through a sense input, so a slave that holds SCL low stretches the high phase instead of cutting it short. Data shifting, arbitration and the register bus belong to other blocks. The four counts are therefore plain inputs.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset SCL is released (scl_drive_low = 0), start_hold = 0 and busy = 0.
- R2: A start_req seen while idle raises start_hold for exactly HCNT+3 clock cycles. SCL stays released during that time, and the first low phase follows directly.
- R3: Each low phase pulls SCL low for exactly LCNT+1 clock cycles. It begins on the cycle the block itself starts driving SCL low.
- R4: When no other device holds SCL, every high phase releases SCL for exactly HCNT+8 clock cycles before the next low phase or the return to idle.
- R5: fast_sel = 1 selects fast_hcnt/fast_lcnt and fast_sel = 0 selects std_hcnt/std_lcnt, both for the start hold and for the SCL phases.
- R6: The high count begins only on the first cycle in which scl_sense is high. While the line is held low after release, the block does not pull SCL low, and the high phase then lasts HCNT+8 cycles from that first high cycle.
- R7: A stop_req seen while busy lets the high phase that is running or comes next finish in full. SCL then stays released and busy falls.
- R8: The counts and fast_sel are sampled when a phase begins. A change during a phase first affects the next phase.
- R9: start_req while busy has no effect on the phase lengths and does not raise start_hold. stop_req while idle has no effect, so the next transfer runs more than one bit.
- R10: The largest count value 2^CNT_W-1 gives the full HCNT+3, LCNT+1 and HCNT+8 lengths without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Begin a transfer (taken only when idle) |
| stop_req | input | 1 | End the transfer after the current or next high phase |
| fast_sel | input | 1 | 1 = fast-speed counts, 0 = standard-speed counts |
| std_hcnt | input | CNT_W | Standard-speed high count |
| std_lcnt | input | CNT_W | Standard-speed low count |
| fast_hcnt | input | CNT_W | Fast-speed high count |
| fast_lcnt | input | CNT_W | Fast-speed low count |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| start_hold | output | 1 | Start-condition hold interval is running |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench builds the block with CNT_W = 8, which keeps every phase within a few hundred cycles. With that width the largest count, 255, lies within reach, so the widened phase counter is tested at its extreme. Small counts such as 2 to 10 give phases short enough to change a count in the middle of a phase and to stretch the clock by a known number of cycles. Separate standard and fast values make a wrong pair visible at once in the measured lengths.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             fast_sel,
  input  logic [CNT_W-1:0] std_hcnt,
  input  logic [CNT_W-1:0] std_lcnt,
  input  logic [CNT_W-1:0] fast_hcnt,
  input  logic [CNT_W-1:0] fast_lcnt,
  input  logic             scl_sense,
  output logic             scl_drive_low,
  output logic             start_hold,
  output logic             busy
);
  localparam int TW = CNT_W + 4;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_LOW, S_WAIT, S_HIGH} st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic          stop_pend;

  wire [TW-1:0] hsel = fast_sel ? TW'(fast_hcnt) : TW'(std_hcnt);
  wire [TW-1:0] lsel = fast_sel ? TW'(fast_lcnt) : TW'(std_lcnt);
  wire          last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start_req) begin
            st  <= S_HOLD;
            cnt <= hsel + TW'(2);
          end
        S_HOLD:
          if (last) begin
            st  <= S_LOW;
            cnt <= lsel;
          end else cnt <= cnt - 1'b1;
        S_LOW:
          if (last) st <= S_WAIT;
          else cnt <= cnt - 1'b1;
        S_WAIT:
          if (scl_sense) begin
            st  <= S_HIGH;
            cnt <= hsel + TW'(6);
          end
        S_HIGH:
          if (last) begin
            st  <= (stop_pend || stop_req) ? S_IDLE : S_LOW;
            cnt <= lsel;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             stop_pend <= 1'b0;
    else if (st == S_IDLE)  stop_pend <= 1'b0;
    else if (stop_req)      stop_pend <= 1'b1;
  end

  assign scl_drive_low = (st == S_LOW);
  assign start_hold    = (st == S_HOLD);
  assign busy          = (st != S_IDLE);
endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic scl_sense,
  input logic scl_drive_low,
  input logic start_hold,
  input logic busy
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_drive_low && !start_hold));

  a_r2_hold_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_hold) |-> ($past(!busy) && $past(start_req)));

  a_r2_hold_then_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_hold) && busy) |-> scl_drive_low);

  a_r6_wait_for_sense: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_hold && !scl_drive_low && !scl_sense) |=> !scl_drive_low);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_hold) |=> !start_hold);

  a_r7_idle_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(!scl_drive_low));
endmodule

bind scl_clock_gen scl_clock_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .scl_sense(scl_sense),
  .scl_drive_low(scl_drive_low), .start_hold(start_hold), .busy(busy)
);

// File: tb/test_scl_clock_gen.sv
module test_scl_clock_gen;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_req = 0, stop_req = 0, fast_sel = 0, stretch = 0;
  logic [CW-1:0] std_hcnt = 5, std_lcnt = 7, fast_hcnt = 2, fast_lcnt = 3;
  logic scl_sense, scl_drive_low, start_hold, busy;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign scl_sense = ~scl_drive_low & ~stretch;

  scl_clock_gen #(.CNT_W(CW)) i_scl_clock_gen (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .fast_sel(fast_sel), .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
    .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt), .scl_sense(scl_sense),
    .scl_drive_low(scl_drive_low), .start_hold(start_hold), .busy(busy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit cond(int which);
    case (which)
      0: return start_hold;
      1: return scl_drive_low;
      default: return busy && !scl_drive_low && !start_hold;
    endcase
  endfunction

  task automatic run_len(input int which, output int n);
    n = 0;
    while (cond(which) && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start_req = 1;
    @(negedge clk);
    start_req = 0;
  endtask

  task automatic frame(int nbits, int h, int l, bit poke, string tag);
    int n;
    pulse_start();
    run_len(0, n); chk({tag, " R2 hold"}, n, h + 3);
    for (int b = 0; b < nbits; b++) begin
      if (b == nbits - 1) stop_req = 1;
      run_len(1, n); chk({tag, " R3 low"}, n, l + 1);
      stop_req = 0;
      if (poke && b == 0) start_req = 1;
      run_len(2, n); chk({tag, " R4 high"}, n, h + 8);
      if (poke && b == 0) begin
        start_req = 0;
        chk({tag, " R9 no hold while busy"}, int'(start_hold), 0);
      end
    end
    chk({tag, " R7 idle after stop"}, int'(busy), 0);
    chk({tag, " R7 scl released"}, int'(scl_drive_low), 0);
  endtask

  task automatic t_reset();
    chk("R1 drive", int'(scl_drive_low), 0);
    chk("R1 hold", int'(start_hold), 0);
    chk("R1 busy", int'(busy), 0);
  endtask

  task automatic t_std();
    fast_sel = 0; std_hcnt = 5; std_lcnt = 7;
    frame(3, 5, 7, 0, "std");
  endtask

  task automatic t_fast();
    fast_sel = 1; fast_hcnt = 2; fast_lcnt = 3;
    frame(2, 2, 3, 0, "R5 fast");
    fast_sel = 0;
  endtask

  task automatic t_stretch();
    int n;
    std_hcnt = 4; std_lcnt = 3;
    pulse_start();
    run_len(0, n); chk("R6 hold", n, 7);
    stretch = 1; stop_req = 1;
    run_len(1, n); chk("R6 low", n, 4);
    stop_req = 0;
    for (int k = 0; k < 6; k++) begin
      chk("R6 no drive while held", int'(scl_drive_low), 0);
      @(negedge clk);
    end
    stretch = 0;
    run_len(2, n); chk("R6 high from first sensed high", n, 12);
    chk("R7 idle after stretched bit", int'(busy), 0);
  endtask

  task automatic t_sample();
    int n;
    std_hcnt = 4; std_lcnt = 6;
    pulse_start();
    run_len(0, n); chk("R8 hold", n, 7);
    fork
      run_len(1, n);
      begin repeat (2) @(negedge clk); std_lcnt = 10; end
    join
    chk("R8 low keeps old count", n, 7);
    fork
      run_len(2, n);
      begin repeat (2) @(negedge clk); std_hcnt = 9; end
    join
    chk("R8 high keeps old count", n, 12);
    stop_req = 1;
    run_len(1, n); chk("R8 next low uses new count", n, 11);
    stop_req = 0;
    run_len(2, n); chk("R8 next high uses new count", n, 17);
    chk("R8 idle", int'(busy), 0);
  endtask

  task automatic t_ignore();
    std_hcnt = 3; std_lcnt = 2;
    stop_req = 1; @(negedge clk); stop_req = 0; @(negedge clk);
    chk("R9 stop in idle busy", int'(busy), 0);
    frame(2, 3, 2, 1, "R9 ignore");
  endtask

  task automatic t_max();
    std_hcnt = 255; std_lcnt = 255;
    frame(1, 255, 255, 0, "R10 max");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_std();
    t_fast();
    t_stretch();
    t_sample();
    t_ignore();
    t_max();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule